// File: doc/BRIEF.md
# Program Interrupt Request Register

This block is a 16-bit register in the I/O page that lets software raise an interrupt request against itself. Software sets request bits in the upper seven bits of the word. Bit 9 asks for level 1 and each higher bit asks for the next level, up to bit 15 for level 7. Hardware keeps the low nine bits. It priority-encodes the highest pending request into a level from 0 to 7 and places that level in two 3-bit fields of the low byte at once.

Whenever the encoded level is nonzero, the block presents an interrupt request at that level with a fixed vector. The processor can present a level on an acknowledge input and learn whether the request for that level is still pending. A bus reset empties the register. Arbitration against other interrupt sources and the trap sequence itself belong to neighbouring logic.

Top module: `prog_irq_reg`

## Requirements
- R1: After the synchronous active-low reset, the register reads 0x0000, `irq_req` is low and `irq_level` is 0.
- R2: A write that hits word address octal 17777772 with `bus_be[1]` set loads bits 15:9 from `bus_wdata[15:9]`. Data on bits 8:0 is ignored.
- R3: A write with only `bus_be[0]` set, or a write to any other address, leaves the register unchanged.
- R4: The level is the index of the highest set bit among 15:9 minus 8, or 0 when none is set. The level appears in bits 7:5 and in bits 3:1, so the low byte equals level × 0x22. Bits 8, 4 and 0 read as zero.
- R5: `irq_req` is high exactly when the level is nonzero, and `irq_level` equals the level. `irq_vector` is octal 240.
- R6: `ack_pending` is high when `ack_strobe` is high, `ack_level` is nonzero and request bit 8+`ack_level` is set. In every other case it is low.
- R7: `bus_reset` clears all request bits on the next edge. This drops any pending request.
- R8: A read that hits the register returns the full word on `bus_rdata` one cycle later, and the word is the value from before that edge. In every other cycle `bus_rdata` is zero.
- R9: After a write clears the highest request bit, the level and the request output move on the same edge to the next highest pending level, or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Synchronous bus reset, clears the requests |
| bus_addr | input | 22 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables, bit 1 is the upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Requested level |
| irq_vector | output | 9 | Fixed vector, octal 240 |
| ack_strobe | input | 1 | Acknowledge check enable |
| ack_level | input | 3 | Level being acknowledged |
| ack_pending | output | 1 | Request at `ack_level` is still set |

## Verification
Register contents, the encoded low byte, `irq_req` and `irq_level` change at the edge that takes a write or a bus reset. `bus_rdata` shows a read one edge after it is presented, and it carries the word from before that edge. `ack_pending` follows its inputs with no delay. The bench drives each cycle's inputs just after a falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, and it keeps the pre-edge word for the read comparison.

// File: rtl/pirq_pkg.sv
// Package: shared constants for the program interrupt request register.
// Assumes a 16-bit word with seven request bits above a 9-bit hardware field.
package pirq_pkg;
    localparam int DATA_W  = 16;
    localparam int LVL_W   = 3;
    localparam int NREQ    = (1 << LVL_W) - 1;
    localparam int REQ_LSB = DATA_W - NREQ;
    localparam int VEC_W   = 9;
    localparam logic [VEC_W-1:0] VECTOR = 9'o240;
endpackage

// File: rtl/pirq_bus_if.sv
// Module: bus decode and registered read path.
// Assumes word-aligned decode (address bit 0 ignored) and a single-cycle strobe protocol.
module pirq_bus_if #(
    parameter int ADDR_W = 22,
    parameter logic [ADDR_W-1:0] REG_ADDR = 22'o17777772,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] reg_word,
    output logic              wr_hi,
    output logic              wr_lo_only,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit;

    // Decode the word address.
    always_comb begin
        hit        = (bus_addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);
        wr_hi      = hit && bus_wr && bus_be[1];
        wr_lo_only = hit && bus_wr && bus_be[0] && !bus_be[1];
    end

    // Capture the word on a read hit and return zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (hit && bus_rd)
            bus_rdata <= reg_word;
        else
            bus_rdata <= '0;
    end

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_rd) |=> (bus_rdata == '0));

    // R8
    read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd) |=> (bus_rdata == $past(reg_word)));
endmodule

// File: rtl/pirq_req_store.sv
// Module: holds the software request bits.
// Assumes bus_reset and rst_n are synchronous, and that rst_n takes priority.
module pirq_req_store #(
    parameter int NREQ = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            wr_hi,
    input  logic            wr_lo_only,
    input  logic [NREQ-1:0] wdata_req,
    output logic [NREQ-1:0] req
);
    // Load request bits on an upper-lane write and clear them on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset)
            req <= '0;
        else if (wr_hi)
            req <= wdata_req;
    end

    // R7
    bus_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (req == '0));

    // R3
    low_lane_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_only && !bus_reset) |=> $stable(req));

    // R2
    upper_lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !bus_reset) |=> (req == $past(wdata_req)));
endmodule

// File: rtl/pirq_encoder.sv
// Module: binary-search priority encoder over the request bits.
// Assumes request i (0-based) stands for level i+1, so level 0 means none pending.
module pirq_encoder #(
    parameter int LVL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [(1<<LVL_W)-2:0]      req,
    output logic [LVL_W-1:0]           level
);
    localparam int SLOTS = 1 << LVL_W;

    logic [SLOTS-1:0] slots;
    int unsigned      base;
    int unsigned      span;

    // Halve the search window each step and move up when the upper half holds a request.
    always_comb begin
        slots = {req, 1'b0};
        base  = 0;
        span  = 0;
        for (int s = LVL_W - 1; s >= 0; s--) begin
            span = 1 << s;
            if (((slots >> (base + span)) & SLOTS'((1 << span) - 1)) != '0)
                base = base + span;
        end
        level = LVL_W'(base);
    end

    // R4
    level_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0) |-> slots[level]);

    // R4
    no_higher_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slots >> level) >> 1) == '0);
endmodule

// File: rtl/prog_irq_reg.sv
// Module: top of the program interrupt request register.
// Assumes a 16-bit bus with byte lanes; the low nine bits are read-only and
// rebuilt from the encoded level; the vector is fixed.
module prog_irq_reg
    import pirq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter logic [ADDR_W-1:0] REG_ADDR = 22'o17777772
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_req,
    output logic [2:0]        irq_level,
    output logic [8:0]        irq_vector,
    input  logic              ack_strobe,
    input  logic [2:0]        ack_level,
    output logic              ack_pending
);
    logic [NREQ-1:0]   req;
    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] reg_word;
    logic              wr_hi;
    logic              wr_lo_only;

    pirq_bus_if #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_be     (bus_be),
        .reg_word   (reg_word),
        .wr_hi      (wr_hi),
        .wr_lo_only (wr_lo_only),
        .bus_rdata  (bus_rdata)
    );

    pirq_req_store #(.NREQ(NREQ)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .wr_hi      (wr_hi),
        .wr_lo_only (wr_lo_only),
        .wdata_req  (bus_wdata[DATA_W-1:REQ_LSB]),
        .req        (req)
    );

    pirq_encoder #(.LVL_W(LVL_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .level (level)
    );

    // Build the visible word with the level placed in both low-byte fields.
    always_comb begin
        reg_word = {req, 1'b0, level, 1'b0, level, 1'b0};
    end

    // Drive the request outputs and the acknowledge check.
    always_comb begin
        irq_req     = (level != '0);
        irq_level   = level;
        irq_vector  = VECTOR;
        ack_pending = ack_strobe && (ack_level != '0) && req[ack_level - 3'd1];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && bus_rdata == '0));

    // R6
    ack_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pending |-> (irq_req && ack_level <= irq_level));

    // R9
    clear_top_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !bus_reset && bus_wdata[DATA_W-1:REQ_LSB] == '0) |=> !irq_req);
endmodule

// File: tb/test_prog_irq_reg.sv
// Bench: behavioural reference model compared on every clock.
module test_prog_irq_reg;
    localparam int ADDR_W = 22;
    localparam logic [ADDR_W-1:0] A_REG = 22'o17777772;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic [21:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic [8:0]  irq_vector;
    logic        ack_strobe = 1'b0;
    logic [2:0]  ack_level = '0;
    logic        ack_pending;

    int compared = 0;
    int mismatched = 0;
    int m_req = 0;
    int exp_rdata[$];
    string tag = "R1";

    always #10 clk = ~clk;

    prog_irq_reg i_prog_irq_reg (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vector(irq_vector), .ack_strobe(ack_strobe), .ack_level(ack_level),
        .ack_pending(ack_pending)
    );

    function automatic int m_level(int r);
        for (int k = 7; k >= 1; k--)
            if (((r >> (k - 1)) & 1) != 0) return k;
        return 0;
    endfunction

    function automatic int m_word(int r);
        return ((r << 9) | (m_level(r) * 'h22)) & 'hffff;
    endfunction

    task automatic check(string req_id, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", req_id, tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs, advance the model at the edge, compare at the falling edge.
    task automatic step(logic rd, logic wr, logic [1:0] be, logic [21:0] addr,
                        logic [15:0] wd, logic brst, logic ak, logic [2:0] al);
        int nxt;
        bus_rd = rd; bus_wr = wr; bus_be = be; bus_addr = addr; bus_wdata = wd;
        bus_reset = brst; ack_strobe = ak; ack_level = al;
        #1;
        check("R6", ack_pending,
              (ak && al != 0 && ((m_req >> (al - 1)) & 1) != 0) ? 1 : 0);
        exp_rdata.push_back((rd && addr[21:1] == A_REG[21:1]) ? m_word(m_req) : 0);
        nxt = m_req;
        if (brst) nxt = 0;
        else if (wr && be[1] && addr[21:1] == A_REG[21:1]) nxt = (wd >> 9) & 'h7f;
        @(posedge clk);
        m_req = nxt;
        @(negedge clk);
        check("R8", bus_rdata, exp_rdata.pop_front());
        check("R5", irq_req, (m_level(m_req) != 0) ? 1 : 0);
        check("R4", irq_level, m_level(m_req));
        check("R5", irq_vector, 'o240);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", irq_req, 0);
        check("R1", irq_level, 0);
        rst_n = 1'b1;
        tag = "R1";
        step(1, 0, 2'b11, A_REG, 0, 0, 0, 0);
        tag = "R2";
        step(0, 1, 2'b11, A_REG, 16'h0a1ff, 0, 0, 0);
        step(1, 0, 2'b11, A_REG, 0, 0, 1, 3'd5);
        step(0, 0, 2'b00, A_REG, 0, 0, 1, 3'd2);
        tag = "R3";
        step(0, 1, 2'b01, A_REG, 16'hffff, 0, 0, 0);
        step(0, 1, 2'b11, A_REG + 22'd2, 16'hfe00, 0, 0, 0);
        step(1, 0, 2'b11, A_REG | 22'd1, 0, 0, 0, 0);
        tag = "R9";
        step(0, 1, 2'b10, A_REG, 16'h8600, 0, 0, 0);
        step(0, 1, 2'b10, A_REG, 16'h0600, 0, 1, 3'd7);
        step(0, 1, 2'b10, A_REG, 16'h0200, 0, 1, 3'd2);
        step(1, 1, 2'b10, A_REG, 16'h0000, 0, 1, 3'd1);
        step(1, 0, 2'b11, A_REG, 0, 0, 0, 0);
        tag = "R4";
        for (int k = 0; k < 128; k++)
            step(1, 1, 2'b10, A_REG, 16'(k << 9), 0, 1, 3'(k % 8));
        tag = "R7";
        step(0, 1, 2'b11, A_REG, 16'hfe00, 0, 0, 0);
        step(1, 1, 2'b11, A_REG, 16'hfe00, 1, 1, 3'd7);
        step(1, 0, 2'b11, A_REG, 0, 0, 1, 3'd7);
        tag = "RND";
        for (int n = 0; n < 400; n++)
            step(1'($urandom), 1'($urandom), 2'($urandom),
                 ($urandom % 4 != 0) ? A_REG : 22'($urandom),
                 16'($urandom), ($urandom % 16 == 0), 1'($urandom), 3'($urandom));
        tag = "R1";
        rst_n = 1'b0;
        m_req = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", irq_req, 0);
        check("R1", bus_rdata, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        compared++;
        mismatched++;
        $display("FAIL watchdog (%s) actual=hung expected=done", tag);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule